// File: doc/BRIEF.md
# Configuration Space Index/Data Port Bridge

This block sits on the host's 16-bit I/O port bus and gives software indirect access to device configuration registers through two 32-bit ports. Software first writes a selector word to the index port (0x0CF8). The word holds an enable flag, a bus number, a device number, a function number and a dword index. A later access to the data port (0x0CFC, and bytes up to 0x0CFF) then becomes a configuration read or write on a simple request/acknowledge interface toward the devices. For a read, the returned dword is steered back onto the port bus.

The scheme holds state across accesses. The selector stays latched until the next index-port write, so the two steps are not atomic: an index-port write that lands between them changes the register that the data-port access reaches. The bridge holds the port-bus ready signal low while a configuration cycle is outstanding. A device that never answers is cut off after a fixed number of cycles, and the read then returns all ones.

Port-bus data is right-justified. A byte access carries its data in bits 7:0 and a word access in bits 15:0. The bridge moves the data into the byte lane given by the two low address bits and drives the matching byte enables.

Top module: `cfgport_bridge`

## Requirements
- R1: After reset, `io_rdy` and `cfg_req` are low and the latched selector reads back as 0x00000000.
- R2: A dword write to 0x0CF8 latches the written word with bits 1:0 forced to zero. A dword read of 0x0CF8 returns the latched word. Both accesses complete with `io_rdy` high in the first cycle after the request is sampled.
- R3: A configuration cycle carries the bus from selector bits 23:16, the device from bits 15:11, the function from bits 10:8 and the dword index from bits 7:2.
- R4: With selector bit 31 set, a dword read of 0x0CFC issues a read cycle with byte enables 4'b1111 and returns `cfg_rdata` unchanged on `io_rdata`.
- R5: With selector bit 31 set, a dword write of 0x0CFC issues a write cycle that carries `io_wdata` and byte enables 4'b1111.
- R6: With selector bit 31 clear, a data-port access starts no cycle and completes in one cycle. A read returns all ones within the access size (0xFF for a byte, 0xFFFF for a word, 0xFFFFFFFF for a dword), and a write is dropped.
- R7: `io_size` encodes 0 for byte, 1 for word and 2 for dword. A byte access at 0x0CFC+k drives byte enable bit k and uses lane k. A word access at offset 0 or 2 drives two adjacent enable bits. Write data is shifted up by 8*k bits. Read data is shifted down by 8*k bits, with the bits above the access size reading as zero.
- R8: While `cfg_req` is high, `io_rdy` stays low and the cycle fields stay stable. `io_rdy` pulses for one cycle, in the cycle after the edge at which `cfg_ack` is sampled high, so a device that answers d cycles after the request gives a latency of d+1.
- R9: If no acknowledge arrives within TIMEOUT_CYC cycles, `cfg_req` drops and the access completes at latency TIMEOUT_CYC+1. A read then returns all ones within the access size. An acknowledge arriving in the last cycle of that window is still honoured.
- R10: An index-port write made between a selector write and a data-port access redirects that access to the newly written selector.
- R11: An access outside 0x0CF8–0x0CFF gets no `io_rdy`, starts no cycle and leaves the selector unchanged.
- R12: An access inside the window that is not one of the legal forms completes in one cycle, returns 0xFFFFFFFF on a read and has no other effect. The legal forms are a dword access at 0x0CF8, a byte access anywhere in the data port, a word access at an even offset of the data port, and a dword access at 0x0CFC. Size code 3 is never legal.
- R13: After selector 0x8000000C is written, the cycle targets bus 0, device 0, function 0, dword 3. A byte read at 0x0CFE then returns bits 23:16 of that dword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_req | input | 1 | Port access request, held until `io_rdy` is seen |
| io_wr | input | 1 | 1 = port write, 0 = port read |
| io_addr | input | IO_AW | Port address |
| io_size | input | 2 | Access size: 0 byte, 1 word, 2 dword |
| io_wdata | input | 32 | Right-justified write data |
| io_rdy | output | 1 | One-cycle completion pulse |
| io_rdata | output | 32 | Right-justified read data, valid with `io_rdy` |
| cfg_req | output | 1 | Configuration cycle request, held until ack or timeout |
| cfg_wr | output | 1 | 1 = configuration write |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_fn | output | 3 | Target function number |
| cfg_dword | output | 6 | Target dword index |
| cfg_be | output | 4 | Byte enables of the cycle |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_ack | input | 1 | Device acknowledge |
| cfg_rdata | input | 32 | Device read data, valid with `cfg_ack` |

## Verification
Accesses that the bridge completes itself become ready one cycle after the request is sampled. These are selector accesses, disabled data-port accesses and illegal accesses inside the window. A configuration access becomes ready d+1 cycles after the request, where d is the device's answer delay. With no answer it becomes ready TIMEOUT_CYC+1 cycles after the request. The bench drives and samples on the falling edge and counts falling edges from the request until ready. It compares that count against these figures, with the device model's delay swept from 1 up to the timeout boundary. It reads the data and the captured cycle fields in that same falling-edge slot.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

   localparam logic [1:0] SZ_BYTE  = 2'd0;
   localparam logic [1:0] SZ_WORD  = 2'd1;
   localparam logic [1:0] SZ_DWORD = 2'd2;

   localparam int unsigned SEL_EN_BIT = 31;
   localparam int unsigned SEL_TGT_HI = 23;
   localparam int unsigned SEL_TGT_LO = 2;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_ADDR = 2'd1,
      ACC_DATA = 2'd2,
      ACC_BAD  = 2'd3
   } acc_kind_e;

   typedef struct packed {
      logic [7:0] bus;
      logic [4:0] dev;
      logic [2:0] fn;
      logic [5:0] dw;
   } cfg_tgt_t;

   function automatic logic [3:0] lane_mask(input logic [1:0] sz, input logic [1:0] off);
      case (sz)
         SZ_BYTE: return 4'b0001 << off;
         SZ_WORD: return 4'b0011 << off;
         default: return 4'b1111;
      endcase
   endfunction

   function automatic logic [31:0] data_mask(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: return 32'h0000_00FF;
         SZ_WORD: return 32'h0000_FFFF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/cfgport_decode.sv
module cfgport_decode
   import cfgport_pkg::*;
#(
   parameter int unsigned          IO_AW          = 16,
   parameter logic [IO_AW-1:0]     ADDR_PORT      = 'h0CF8,
   parameter logic [IO_AW-1:0]     DATA_PORT      = 'h0CFC,
   parameter bit                   ALLOW_SUBDWORD = 1'b1
) (
   input  logic [IO_AW-1:0] io_addr,
   input  logic [1:0]       io_size,
   output acc_kind_e        kind,
   output logic [1:0]       lane,
   output logic [3:0]       be
);

   localparam logic [IO_AW-3:0] ADDR_TAG = ADDR_PORT[IO_AW-1:2];
   localparam logic [IO_AW-3:0] DATA_TAG = DATA_PORT[IO_AW-1:2];

   if (IO_AW < 3) begin : g_bad_aw
      $error("cfgport_decode: IO_AW must be at least 3");
   end
   if (ADDR_PORT[1:0] != 2'b00 || DATA_PORT[1:0] != 2'b00) begin : g_bad_align
      $error("cfgport_decode: ports must be dword aligned");
   end
   if (ADDR_TAG == DATA_TAG) begin : g_bad_overlap
      $error("cfgport_decode: index and data ports must differ");
   end

   logic hit_addr;
   logic hit_data;
   logic data_ok;

   assign hit_addr = (io_addr[IO_AW-1:2] == ADDR_TAG);
   assign hit_data = (io_addr[IO_AW-1:2] == DATA_TAG);
   assign lane     = io_addr[1:0];
   assign be       = lane_mask(io_size, lane);

   if (ALLOW_SUBDWORD) begin : g_subdword
      always_comb begin
         case (io_size)
            SZ_BYTE:  data_ok = 1'b1;
            SZ_WORD:  data_ok = ~lane[0];
            SZ_DWORD: data_ok = (lane == 2'b00);
            default:  data_ok = 1'b0;
         endcase
      end
   end else begin : g_dword_only
      assign data_ok = (io_size == SZ_DWORD) && (lane == 2'b00);
   end

   always_comb begin
      if (hit_addr) begin
         kind = ((io_size == SZ_DWORD) && (lane == 2'b00)) ? ACC_ADDR : ACC_BAD;
      end else if (hit_data) begin
         kind = data_ok ? ACC_DATA : ACC_BAD;
      end else begin
         kind = ACC_NONE;
      end
   end

endmodule

// File: rtl/cfgport_addr_latch.sv
module cfgport_addr_latch
   import cfgport_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wdata,
   output logic [31:0] q,
   output logic        en,
   output cfg_tgt_t    tgt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr_en) begin
         q <= wdata & 32'hFFFF_FFFC;
      end
   end

   assign en  = q[SEL_EN_BIT];
   assign tgt = cfg_tgt_t'(q[SEL_TGT_HI:SEL_TGT_LO]);

endmodule

// File: rtl/cfgport_cycle.sv
module cfgport_cycle
   import cfgport_pkg::*;
#(
   parameter int unsigned TIMEOUT_CYC    = 16,
   parameter bit          ALLOW_SUBDWORD = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        io_req,
   input  logic        io_wr,
   input  logic [1:0]  io_size,
   input  logic [31:0] io_wdata,
   input  acc_kind_e   kind,
   input  logic [1:0]  lane,
   input  logic [3:0]  be,
   input  logic [31:0] latch_q,
   input  logic        sel_en,
   input  cfg_tgt_t    sel_tgt,
   output logic        lat_we,
   output logic        io_rdy,
   output logic [31:0] io_rdata,
   output logic        cfg_req,
   output logic        cfg_wr,
   output cfg_tgt_t    cfg_tgt,
   output logic [3:0]  cfg_be,
   output logic [31:0] cfg_wdata,
   input  logic        cfg_ack,
   input  logic [31:0] cfg_rdata
);

   localparam int unsigned      CNT_W    = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CFG  = 2'd1,
      ST_DONE = 2'd2
   } st_e;

   st_e              st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [1:0]       lane_q;
   logic [1:0]       size_q;
   logic [31:0]      rdata_q;
   logic [31:0]      wdata_lane;
   logic [31:0]      rd_lane;

   if (ALLOW_SUBDWORD) begin : g_steer
      assign wdata_lane = io_wdata << {lane, 3'b000};
      assign rd_lane    = cfg_rdata >> {lane_q, 3'b000};
   end else begin : g_flat
      assign wdata_lane = io_wdata;
      assign rd_lane    = cfg_rdata;
   end

   assign lat_we   = (st_q == ST_IDLE) && io_req && (kind == ACC_ADDR) && io_wr;
   assign io_rdy   = (st_q == ST_DONE);
   assign io_rdata = rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         cnt_q     <= '0;
         lane_q    <= '0;
         size_q    <= '0;
         rdata_q   <= '0;
         cfg_req   <= 1'b0;
         cfg_wr    <= 1'b0;
         cfg_tgt   <= '0;
         cfg_be    <= '0;
         cfg_wdata <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (io_req) begin
                  case (kind)
                     ACC_ADDR: begin
                        rdata_q <= latch_q;
                        st_q    <= ST_DONE;
                     end
                     ACC_DATA: begin
                        if (sel_en) begin
                           cfg_req   <= 1'b1;
                           cfg_wr    <= io_wr;
                           cfg_tgt   <= sel_tgt;
                           cfg_be    <= be;
                           cfg_wdata <= wdata_lane;
                           lane_q    <= lane;
                           size_q    <= io_size;
                           cnt_q     <= '0;
                           st_q      <= ST_CFG;
                        end else begin
                           rdata_q <= data_mask(io_size);
                           st_q    <= ST_DONE;
                        end
                     end
                     ACC_BAD: begin
                        rdata_q <= '1;
                        st_q    <= ST_DONE;
                     end
                     default: ;
                  endcase
               end
            end
            ST_CFG: begin
               if (cfg_ack) begin
                  rdata_q <= rd_lane & data_mask(size_q);
                  cfg_req <= 1'b0;
                  st_q    <= ST_DONE;
               end else if (cnt_q == CNT_LAST) begin
                  rdata_q <= data_mask(size_q);
                  cfg_req <= 1'b0;
                  st_q    <= ST_DONE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_DONE: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cfgport_bridge.sv
module cfgport_bridge
   import cfgport_pkg::*;
#(
   parameter int unsigned      IO_AW          = 16,
   parameter logic [IO_AW-1:0] ADDR_PORT      = 'h0CF8,
   parameter logic [IO_AW-1:0] DATA_PORT      = 'h0CFC,
   parameter int unsigned      TIMEOUT_CYC    = 16,
   parameter bit               ALLOW_SUBDWORD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             io_req,
   input  logic             io_wr,
   input  logic [IO_AW-1:0] io_addr,
   input  logic [1:0]       io_size,
   input  logic [31:0]      io_wdata,
   output logic             io_rdy,
   output logic [31:0]      io_rdata,
   output logic             cfg_req,
   output logic             cfg_wr,
   output logic [7:0]       cfg_bus,
   output logic [4:0]       cfg_dev,
   output logic [2:0]       cfg_fn,
   output logic [5:0]       cfg_dword,
   output logic [3:0]       cfg_be,
   output logic [31:0]      cfg_wdata,
   input  logic             cfg_ack,
   input  logic [31:0]      cfg_rdata
);

   if (TIMEOUT_CYC < 1) begin : g_bad_timeout
      $error("cfgport_bridge: TIMEOUT_CYC must be at least 1");
   end

   acc_kind_e   kind;
   logic [1:0]  lane;
   logic [3:0]  be;
   logic        lat_we;
   logic [31:0] lat_q;
   logic        sel_en;
   cfg_tgt_t    sel_tgt;
   cfg_tgt_t    cyc_tgt;

   cfgport_decode #(
      .IO_AW          (IO_AW),
      .ADDR_PORT      (ADDR_PORT),
      .DATA_PORT      (DATA_PORT),
      .ALLOW_SUBDWORD (ALLOW_SUBDWORD)
   ) u_decode (
      .io_addr (io_addr),
      .io_size (io_size),
      .kind    (kind),
      .lane    (lane),
      .be      (be)
   );

   cfgport_addr_latch u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (lat_we),
      .wdata (io_wdata),
      .q     (lat_q),
      .en    (sel_en),
      .tgt   (sel_tgt)
   );

   cfgport_cycle #(
      .TIMEOUT_CYC    (TIMEOUT_CYC),
      .ALLOW_SUBDWORD (ALLOW_SUBDWORD)
   ) u_cycle (
      .clk       (clk),
      .rst_n     (rst_n),
      .io_req    (io_req),
      .io_wr     (io_wr),
      .io_size   (io_size),
      .io_wdata  (io_wdata),
      .kind      (kind),
      .lane      (lane),
      .be        (be),
      .latch_q   (lat_q),
      .sel_en    (sel_en),
      .sel_tgt   (sel_tgt),
      .lat_we    (lat_we),
      .io_rdy    (io_rdy),
      .io_rdata  (io_rdata),
      .cfg_req   (cfg_req),
      .cfg_wr    (cfg_wr),
      .cfg_tgt   (cyc_tgt),
      .cfg_be    (cfg_be),
      .cfg_wdata (cfg_wdata),
      .cfg_ack   (cfg_ack),
      .cfg_rdata (cfg_rdata)
   );

   assign cfg_bus   = cyc_tgt.bus;
   assign cfg_dev   = cyc_tgt.dev;
   assign cfg_fn    = cyc_tgt.fn;
   assign cfg_dword = cyc_tgt.dw;

endmodule

// File: rtl/cfgport_bridge_chk.sv
module cfgport_bridge_chk #(
   parameter int unsigned TIMEOUT_CYC = 16
) (
   input logic        clk,
   input logic        rst_n,
   input logic        io_rdy,
   input logic        cfg_req,
   input logic        cfg_ack,
   input logic        cfg_wr,
   input logic [7:0]  cfg_bus,
   input logic [4:0]  cfg_dev,
   input logic [2:0]  cfg_fn,
   input logic [5:0]  cfg_dword,
   input logic [3:0]  cfg_be,
   input logic [31:0] cfg_wdata,
   input logic [31:0] lat_q
);

   logic [31:0] wait_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wait_cnt <= '0;
      else        wait_cnt <= cfg_req ? wait_cnt + 32'd1 : 32'd0;
   end

   AST_LATCH_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      lat_q[1:0] == 2'b00); // R2

   AST_FIELDS_FROM_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_req) |-> {cfg_bus, cfg_dev, cfg_fn, cfg_dword} == lat_q[23:2]); // R3

   AST_CYCLE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_req) |-> lat_q[31]); // R6

   AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req |-> (cfg_be inside {4'b0001, 4'b0010, 4'b0100, 4'b1000,
                                  4'b0011, 4'b1100, 4'b1111})); // R7

   AST_REQ_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req && $past(cfg_req) |->
         $stable({cfg_wr, cfg_bus, cfg_dev, cfg_fn, cfg_dword, cfg_be, cfg_wdata})); // R8

   AST_NO_RDY_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req |-> !io_rdy); // R8

   AST_RDY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req && cfg_ack |=> io_rdy && !cfg_req); // R8

   AST_RDY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      io_rdy |=> !io_rdy); // R8

   AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req |-> wait_cnt < TIMEOUT_CYC); // R9

endmodule

bind cfgport_bridge cfgport_bridge_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .io_rdy    (io_rdy),
   .cfg_req   (cfg_req),
   .cfg_ack   (cfg_ack),
   .cfg_wr    (cfg_wr),
   .cfg_bus   (cfg_bus),
   .cfg_dev   (cfg_dev),
   .cfg_fn    (cfg_fn),
   .cfg_dword (cfg_dword),
   .cfg_be    (cfg_be),
   .cfg_wdata (cfg_wdata),
   .lat_q     (lat_q)
);

// File: tb/cfgport_bridge_bench.sv
module cfgport_bridge_bench;

   localparam int CLK_PERIOD = 10;
   localparam int TMO        = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_req = 1'b0;
   logic        io_wr = 1'b0;
   logic [15:0] io_addr = '0;
   logic [1:0]  io_size = '0;
   logic [31:0] io_wdata = '0;
   logic        io_rdy;
   logic [31:0] io_rdata;
   logic        cfg_req;
   logic        cfg_wr;
   logic [7:0]  cfg_bus;
   logic [4:0]  cfg_dev;
   logic [2:0]  cfg_fn;
   logic [5:0]  cfg_dword;
   logic [3:0]  cfg_be;
   logic [31:0] cfg_wdata;
   logic        cfg_ack = 1'b0;
   logic [31:0] cfg_rdata = '0;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   cfgport_bridge #(.TIMEOUT_CYC(TMO)) u_cfgport_bridge (
      .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_wr(io_wr), .io_addr(io_addr),
      .io_size(io_size), .io_wdata(io_wdata), .io_rdy(io_rdy), .io_rdata(io_rdata),
      .cfg_req(cfg_req), .cfg_wr(cfg_wr), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev),
      .cfg_fn(cfg_fn), .cfg_dword(cfg_dword), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
      .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata)
   );

   // device model
   int          dev_lat = 1;
   bit          dev_mute = 1'b0;
   int          dev_cnt = 0;
   int          cyc_count = 0;
   int          wr_count = 0;
   logic [21:0] log_tgt = '0;
   logic [3:0]  log_be = '0;
   logic [31:0] log_wdata = '0;

   function automatic logic [31:0] devdata(input logic [21:0] tgt);
      return 32'h9E37_79B9 * ({10'd0, tgt} + 32'd1);
   endfunction

   function automatic logic [31:0] szmask(input logic [1:0] sz);
      return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
   endfunction

   function automatic logic [31:0] bemask(input logic [3:0] b);
      logic [31:0] m = '0;
      for (int i = 0; i < 4; i++) if (b[i]) m[8*i +: 8] = 8'hFF;
      return m;
   endfunction

   always @(negedge clk) begin
      if (!rst_n) begin
         cfg_ack = 1'b0;
         dev_cnt = 0;
      end else if (cfg_ack) begin
         cfg_ack = 1'b0;
         dev_cnt = 0;
      end else if (cfg_req) begin
         if (dev_cnt == 0) cyc_count++;
         dev_cnt++;
         if (!dev_mute && dev_cnt == dev_lat) begin
            cfg_ack   = 1'b1;
            log_tgt   = {cfg_bus, cfg_dev, cfg_fn, cfg_dword};
            log_be    = cfg_be;
            cfg_rdata = devdata(log_tgt);
            if (cfg_wr) begin
               wr_count++;
               log_wdata = cfg_wdata;
            end
         end
      end else begin
         dev_cnt = 0;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic io_op(input logic [15:0] a, input logic [1:0] sz, input logic wr,
                        input logic [31:0] wd, output logic [31:0] rd, output int lat);
      io_addr = a; io_size = sz; io_wr = wr; io_wdata = wd; io_req = 1'b1;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!io_rdy && lat < 1000);
      rd = io_rdata;
      io_req = 1'b0;
      @(negedge clk);
   endtask

   task automatic set_sel(input logic [31:0] v);
      logic [31:0] rd;
      int lat;
      io_op(16'h0CF8, 2'd2, 1'b1, v, rd, lat);
   endtask

   task automatic get_sel(output logic [31:0] v);
      int lat;
      io_op(16'h0CF8, 2'd2, 1'b0, 32'h0, v, lat);
   endtask

   task automatic probe_outside(input logic [15:0] a);
      int seen = 0;
      int c0 = cyc_count;
      io_addr = a; io_size = 2'd2; io_wr = 1'b1; io_wdata = 32'hFFFF_FFFF; io_req = 1'b1;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (io_rdy || cfg_req) seen++;
      end
      io_req = 1'b0;
      @(negedge clk);
      chk("R11 no response outside window", 32'(seen), 32'd0);
      chk("R11 no cycle outside window", 32'(cyc_count - c0), 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] rd, sv, exp;
      logic [21:0] tgt;
      int lat, c0, w0;

      repeat (3) @(negedge clk);
      chk("R1 io_rdy low in reset", 32'(io_rdy), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 io_rdy low after reset", 32'(io_rdy), 32'd0);
      chk("R1 cfg_req low after reset", 32'(cfg_req), 32'd0);
      io_op(16'h0CF8, 2'd2, 1'b0, 0, rd, lat);
      chk("R1 selector reset value", rd, 32'h0);
      chk("R2 read latency", 32'(lat), 32'd1);

      // R2 latch and low bits
      io_op(16'h0CF8, 2'd2, 1'b1, 32'h8A5F_3BC7, rd, lat);
      chk("R2 write latency", 32'(lat), 32'd1);
      get_sel(sv);
      chk("R2 readback low bits zero", sv, 32'h8A5F_3BC4);

      // R6 disabled
      set_sel(32'h0001_2304);
      c0 = cyc_count; w0 = wr_count;
      io_op(16'h0CFC, 2'd2, 1'b0, 0, rd, lat);
      chk("R6 disabled dword read", rd, 32'hFFFF_FFFF);
      chk("R6 disabled latency", 32'(lat), 32'd1);
      io_op(16'h0CFD, 2'd0, 1'b0, 0, rd, lat);
      chk("R6 disabled byte read", rd, 32'h0000_00FF);
      io_op(16'h0CFE, 2'd1, 1'b0, 0, rd, lat);
      chk("R6 disabled word read", rd, 32'h0000_FFFF);
      io_op(16'h0CFC, 2'd2, 1'b1, 32'h1234_5678, rd, lat);
      chk("R6 disabled write latency", 32'(lat), 32'd1);
      chk("R6 no cycle when disabled", 32'(cyc_count - c0), 32'd0);
      chk("R6 write dropped", 32'(wr_count - w0), 32'd0);

      // R3/R4/R8 sweep over device and function
      for (int d = 0; d < 32; d++) begin
         for (int f = 0; f < 8; f++) begin
            logic [5:0] dw;
            dw = 6'((d * 8 + f) % 64);
            tgt = {8'h5A, 5'(d), 3'(f), dw};
            set_sel({1'b1, 7'h00, tgt, 2'b00});
            dev_lat = 1 + (d + f) % 4;
            io_op(16'h0CFC, 2'd2, 1'b0, 0, rd, lat);
            chk("R4 dword read data", rd, devdata(tgt));
            chk("R4 dword read byte enables", 32'(log_be), 32'hF);
            chk("R3 cycle fields", 32'(log_tgt), 32'(tgt));
            chk("R8 latency equals device delay plus one", 32'(lat), 32'(dev_lat + 1));
         end
      end

      // R5 dword write
      tgt = {8'h11, 5'd20, 3'd5, 6'd40};
      set_sel({1'b1, 7'h00, tgt, 2'b00});
      dev_lat = 2;
      w0 = wr_count;
      io_op(16'h0CFC, 2'd2, 1'b1, 32'hDEAD_BEEF, rd, lat);
      chk("R5 write issued", 32'(wr_count - w0), 32'd1);
      chk("R5 write data", log_wdata, 32'hDEAD_BEEF);
      chk("R5 write byte enables", 32'(log_be), 32'hF);
      chk("R5 write target", 32'(log_tgt), 32'(tgt));

      // R7 byte and word lanes
      tgt = {8'h03, 5'd7, 3'd2, 6'd10};
      set_sel({1'b1, 7'h00, tgt, 2'b00});
      for (int k = 0; k < 4; k++) begin
         dev_lat = 1 + k;
         io_op(16'h0CFC + 16'(k), 2'd0, 1'b0, 0, rd, lat);
         chk("R7 byte read lane", rd, (devdata(tgt) >> (8 * k)) & 32'hFF);
         chk("R7 byte read enable", 32'(log_be), 32'(4'b0001 << k));
         io_op(16'h0CFC + 16'(k), 2'd0, 1'b1, 32'h0000_00C3 + 32'(k), rd, lat);
         exp = (32'h0000_00C3 + 32'(k)) << (8 * k);
         chk("R7 byte write enable", 32'(log_be), 32'(4'b0001 << k));
         chk("R7 byte write lane data", log_wdata & bemask(log_be), exp);
      end
      for (int k = 0; k < 4; k += 2) begin
         io_op(16'h0CFC + 16'(k), 2'd1, 1'b0, 0, rd, lat);
         chk("R7 word read lane", rd, (devdata(tgt) >> (8 * k)) & 32'hFFFF);
         chk("R7 word read enable", 32'(log_be), 32'(4'b0011 << k));
         io_op(16'h0CFC + 16'(k), 2'd1, 1'b1, 32'h0000_A55A, rd, lat);
         chk("R7 word write enable", 32'(log_be), 32'(4'b0011 << k));
         chk("R7 word write lane data", log_wdata & bemask(log_be), 32'h0000_A55A << (8 * k));
      end

      // R12 illegal forms inside the window
      set_sel(32'h8000_1100);
      c0 = cyc_count;
      io_op(16'h0CFD, 2'd1, 1'b0, 0, rd, lat);
      chk("R12 misaligned word read", rd, 32'hFFFF_FFFF);
      chk("R12 misaligned word latency", 32'(lat), 32'd1);
      io_op(16'h0CF9, 2'd0, 1'b0, 0, rd, lat);
      chk("R12 byte read of index port", rd, 32'hFFFF_FFFF);
      io_op(16'h0CFC, 2'd3, 1'b0, 0, rd, lat);
      chk("R12 reserved size read", rd, 32'hFFFF_FFFF);
      io_op(16'h0CF8, 2'd0, 1'b1, 32'h0000_0077, rd, lat);
      io_op(16'h0CFA, 2'd1, 1'b1, 32'h0000_7777, rd, lat);
      chk("R12 no cycle for illegal forms", 32'(cyc_count - c0), 32'd0);
      get_sel(sv);
      chk("R12 selector unchanged", sv, 32'h8000_1100);

      // R10 intervening index write
      set_sel({1'b1, 7'h00, 8'h02, 5'd3, 3'd1, 6'd4, 2'b00});
      set_sel({1'b1, 7'h00, 8'h02, 5'd9, 3'd6, 6'd12, 2'b00});
      dev_lat = 1;
      io_op(16'h0CFC, 2'd2, 1'b0, 0, rd, lat);
      tgt = {8'h02, 5'd9, 3'd6, 6'd12};
      chk("R10 redirected target", 32'(log_tgt), 32'(tgt));
      chk("R10 redirected data", rd, devdata(tgt));

      // R13 header-type example
      set_sel(32'h8000_000C);
      io_op(16'h0CFE, 2'd0, 1'b0, 0, rd, lat);
      chk("R13 target dword 3", 32'(log_tgt), 32'h3);
      chk("R13 header byte", rd, (devdata(22'h3) >> 16) & 32'hFF);

      // R9 timeout
      tgt = {8'h40, 5'd1, 3'd0, 6'd2};
      set_sel({1'b1, 7'h00, tgt, 2'b00});
      dev_mute = 1'b1;
      io_op(16'h0CFC, 2'd2, 1'b0, 0, rd, lat);
      chk("R9 timeout read data", rd, 32'hFFFF_FFFF);
      chk("R9 timeout latency", 32'(lat), 32'(TMO + 1));
      io_op(16'h0CFF, 2'd0, 1'b0, 0, rd, lat);
      chk("R9 timeout byte read", rd, 32'h0000_00FF);
      w0 = wr_count;
      io_op(16'h0CFC, 2'd2, 1'b1, 32'h5555_AAAA, rd, lat);
      chk("R9 timeout write latency", 32'(lat), 32'(TMO + 1));
      chk("R9 timeout write not acknowledged", 32'(wr_count - w0), 32'd0);
      chk("R9 cfg_req dropped", 32'(cfg_req), 32'd0);
      dev_mute = 1'b0;
      dev_lat = TMO;
      io_op(16'h0CFC, 2'd2, 1'b0, 0, rd, lat);
      chk("R9 ack in last window cycle honoured", rd, devdata(tgt));
      chk("R9 boundary latency", 32'(lat), 32'(TMO + 1));

      // R11 outside window
      set_sel(32'h8012_3458);
      probe_outside(16'h0CF4);
      probe_outside(16'h0D00);
      probe_outside(16'h1CF8);
      get_sel(sv);
      chk("R11 selector unchanged", sv, 32'h8012_3458);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule